// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output cell of a small programmable logic device. It takes the product terms that the logic array has formed for one output and turns them into the signals for one bidirectional pad: the value to drive, the drive enable, and the feedback bit that goes back into the array. The cell can act as a clocked output, a combinational output, a combinational pin with its own enable, or a pure input.

Two device-wide mode bits (`gmode`) are shared by every cell. One per-cell bit (`loc_sel`) selects between the two behaviours that each device mode allows. Four internal selectors follow from these three bits. One routes the terms into the OR gate. One picks between the register and the combinational sum for the pad. One picks the drive enable. One picks the feedback source. A per-cell polarity bit inverts the pad value. In clocked mode the inversion is applied after the flip-flop.

The pad is modelled as separate `pad_i`, `pad_o` and `pad_oe` signals. Driving the wire is left to the pad ring. The shared clock and the shared active-low output enable only take effect in clocked mode. In the other modes the device uses those pins as ordinary array inputs.

Top module: `pal_out_cell`

## Requirements
- R1: Mode decode from {gmode, loc_sel}: 2'b10/0 is clocked output, 2'b10/1 and 2'b01/0 are combinational I/O, 2'b00/0 is combinational output, and every other combination (2'b01/1, 2'b00/1, 2'b11/x) is input-only.
- R2: In clocked mode, each rising `clk` edge stores the OR of all NT terms, and after that edge `pad_o` equals the stored bit XOR `pol_inv`.
- R3: In clocked mode, `pad_oe` equals the inverse of `oe_n`, and `fb` equals the stored bit before polarity inversion.
- R4: In combinational I/O mode, `pad_o` is the OR of terms pt[NT-1:1] XOR `pol_inv`, `pad_oe` equals pt[0], and `fb` equals `pad_i`.
- R5: In combinational output mode, `pad_o` is the OR of all NT terms XOR `pol_inv`, `pad_oe` is 1, and `fb` is 0.
- R6: In input-only mode, `pad_oe` is 0 whatever `oe_n` and the terms are, and `fb` equals `pad_i`.
- R7: In clocked mode, a change of `pol_inv` alone flips `pad_o` at once, with no clock edge and no change to the stored bit.
- R8: A rising `clk` edge with `rst` high clears the stored bit, so in clocked mode `pad_o` then equals `pol_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst | input | 1 | Synchronous clear of the cell flip-flop, used for simulation start-up |
| gmode | input | 2 | Device-wide mode bits |
| loc_sel | input | 1 | Per-cell mode bit |
| pol_inv | input | 1 | 1 makes the pad value active-low |
| pt | input | NT | Product terms from the array; pt[0] doubles as the enable term |
| oe_n | input | 1 | Shared active-low output enable for clocked cells |
| pad_i | input | 1 | Value currently seen on the pad |
| pad_o | output | 1 | Value to drive on the pad |
| pad_oe | output | 1 | Pad drive enable; 0 means high impedance |
| fb | output | 1 | Feedback bit into the array |

## Verification
The checker tests these properties on every cycle:
- the one-cycle path from terms to pad in clocked mode;
- the enable sources in each mode;
- that input-only mode never drives the pad and always feeds the pad back;
- the cleared pad value after reset.

The bench sweeps every mode and polarity combination against all term patterns and both values of `oe_n` and `pad_i`. Only these scenarios show that the decode has no gaps, for example that 2'b11 falls to input-only. Only they show that a polarity change alone moves the pad without touching the stored bit.

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter int NT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    gmode,
  input  logic          loc_sel,
  input  logic          pol_inv,
  input  logic [NT-1:0] pt,
  input  logic          oe_n,
  input  logic          pad_i,
  output logic          pad_o,
  output logic          pad_oe,
  output logic          fb
);
  localparam logic [1:0] DEV_SIMPLE = 2'b00;
  localparam logic [1:0] DEV_COMB   = 2'b01;
  localparam logic [1:0] DEV_REG    = 2'b10;

  logic use_reg, use_cio, use_cout;
  logic sum_all, sum_lo, comb_sum, core, q;

  assign use_reg  = (gmode == DEV_REG) & ~loc_sel;
  assign use_cio  = ((gmode == DEV_REG) & loc_sel) | ((gmode == DEV_COMB) & ~loc_sel);
  assign use_cout = (gmode == DEV_SIMPLE) & ~loc_sel;

  assign sum_all = |pt;
  assign sum_lo  = |pt[NT-1:1];

  // term selector: pt[0] is taken out of the sum when it serves as enable
  assign comb_sum = use_cio ? sum_lo : sum_all;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sum_all;
  end

  // data selector, then polarity after the register
  assign core  = use_reg ? q : comb_sum;
  assign pad_o = core ^ pol_inv;

  // enable selector
  always_comb begin
    if (use_reg)       pad_oe = ~oe_n;
    else if (use_cio)  pad_oe = pt[0];
    else if (use_cout) pad_oe = 1'b1;
    else               pad_oe = 1'b0;
  end

  // feedback selector
  always_comb begin
    if (use_reg)       fb = q;
    else if (use_cout) fb = 1'b0;
    else               fb = pad_i;
  end
endmodule

module pal_out_cell_chk #(
  parameter int NT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    gmode,
  input logic          loc_sel,
  input logic          pol_inv,
  input logic [NT-1:0] pt,
  input logic          oe_n,
  input logic          pad_i,
  input logic          pad_o,
  input logic          pad_oe,
  input logic          fb
);
  logic m_reg, m_cio, m_cout, m_in;
  assign m_reg  = (gmode == 2'b10) && !loc_sel;
  assign m_cio  = (gmode == 2'b10 && loc_sel) || (gmode == 2'b01 && !loc_sel);
  assign m_cout = (gmode == 2'b00) && !loc_sel;
  assign m_in   = !(m_reg || m_cio || m_cout);

  AST_REG_PIPE: assert property (@(posedge clk) disable iff (rst)
    m_reg && $past(!rst) |-> pad_o == ((|$past(pt)) ^ pol_inv)); // R2
  AST_REG_FB: assert property (@(posedge clk) disable iff (rst)
    m_reg && $past(!rst) |-> fb == (|$past(pt))); // R3
  AST_REG_OE: assert property (@(posedge clk) disable iff (rst)
    m_reg |-> pad_oe == !oe_n); // R3
  AST_CIO_OE: assert property (@(posedge clk) disable iff (rst)
    m_cio |-> pad_oe == pt[0] && fb == pad_i); // R4
  AST_COUT_DRIVE: assert property (@(posedge clk) disable iff (rst)
    m_cout |-> pad_oe && !fb); // R5
  AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (rst)
    m_in |-> !pad_oe && fb == pad_i); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $fell(rst) |-> !m_reg || pad_o == pol_inv); // R8
endmodule

bind pal_out_cell pal_out_cell_chk #(.NT(NT)) u_chk (
  .clk(clk), .rst(rst), .gmode(gmode), .loc_sel(loc_sel), .pol_inv(pol_inv),
  .pt(pt), .oe_n(oe_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
);

// File: tb/tb_pal_out_cell.sv
module tb_pal_out_cell;
  localparam int NT = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] gmode = 2'b10;
  logic loc_sel = 1'b0;
  logic pol_inv = 1'b0;
  logic [NT-1:0] pt = '0;
  logic oe_n = 1'b0;
  logic pad_i = 1'b0;
  logic pad_o, pad_oe, fb;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_out_cell #(.NT(NT)) dut (
    .clk(clk), .rst(rst), .gmode(gmode), .loc_sel(loc_sel), .pol_inv(pol_inv),
    .pt(pt), .oe_n(oe_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (gmode=%b loc=%b inv=%b pt=%h oe_n=%b pad_i=%b)",
               req, what, act, exp, gmode, loc_sel, pol_inv, pt, oe_n, pad_i);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic e_oe, e_o, e_fb, kind_reg, kind_cio, kind_cout;
    string rq;
    repeat (2) tick();
    // R8: cleared after reset, clocked mode, both polarities
    chk("R8", "pad_o after reset", pad_o, 1'b0);
    pol_inv = 1'b1; #1;
    chk("R8", "pad_o after reset inv", pad_o, 1'b1);
    pol_inv = 1'b0;
    rst = 1'b0;

    for (int m = 0; m < 16; m++) begin
      gmode   = m[3:2];
      loc_sel = m[1];
      pol_inv = m[0];
      kind_reg  = (m[3:2] == 2'b10) && !m[1];
      kind_cio  = (m[3:2] == 2'b10 && m[1]) || (m[3:2] == 2'b01 && !m[1]);
      kind_cout = (m[3:2] == 2'b00) && !m[1];
      for (int v = 0; v < 1024; v++) begin
        pt    = v[7:0];
        oe_n  = v[8];
        pad_i = v[9];
        tick();
        if (kind_reg) begin
          rq = "R2"; e_o = (|v[7:0]) ^ m[0]; e_oe = !v[8]; e_fb = |v[7:0];
        end else if (kind_cio) begin
          rq = "R4"; e_o = (|v[7:1]) ^ m[0]; e_oe = v[0]; e_fb = v[9];
        end else if (kind_cout) begin
          rq = "R5"; e_o = (|v[7:0]) ^ m[0]; e_oe = 1'b1; e_fb = 1'b0;
        end else begin
          rq = "R6"; e_o = 1'b0; e_oe = 1'b0; e_fb = v[9];
        end
        chk(kind_reg ? "R3" : rq, "pad_oe (R1 decode)", pad_oe, e_oe);
        chk(kind_reg ? "R3" : rq, "fb", fb, e_fb);
        if (e_oe) chk(rq, "pad_o", pad_o, e_o);
      end
    end

    // R7: polarity alone flips the clocked output, no edge
    gmode = 2'b10; loc_sel = 1'b0; pol_inv = 1'b0; pt = 8'h10; oe_n = 1'b0;
    tick();
    chk("R7", "pad_o before flip", pad_o, 1'b1);
    pt = 8'h00; pol_inv = 1'b1; #1;
    chk("R7", "pad_o after flip, no edge", pad_o, 1'b0);
    chk("R7", "fb unchanged", fb, 1'b1);
    tick();
    chk("R2", "pad_o after edge with zero terms", pad_o, 1'b1);

    // R8: mid-run reset with all terms set
    pt = 8'hFF; pol_inv = 1'b0; rst = 1'b1;
    tick();
    chk("R8", "pad_o under reset", pad_o, 1'b0);
    chk("R8", "fb under reset", fb, 1'b0);
    rst = 1'b0;
    tick();
    chk("R2", "pad_o after reset release", pad_o, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule